// File: doc/BRIEF.md
# Thirty-Two Pin General-Purpose I/O Bank with Interrupt Sensing

This block controls a bank of general-purpose pins through a small register port. Software sets a drive latch and a per-pin drive-enable mask. The bank drives the latch onto the pad outputs and the mask onto the pad enables. Pad levels come back through a synchronizer chain and are readable as a word. A separate readback register returns the drive latch exactly, so software never depends on the delayed synchronized view to learn what it last wrote.

Every pin has its own event detector. Three sense-select bits per pin choose one of five modes: falling edge, rising edge, both edges, low level or high level. A detected event sets a sticky status bit, whether or not the pin is enabled. Software clears status bits by writing ones to them. The single interrupt output is raised while any status bit is set and its enable bit is also set.

The register port is single-cycle. A write is captured on the clock edge where `bus_sel` and `bus_wr` are both high. Read data is a combinational function of `bus_addr`.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register is zero, `pin_out` and `pin_oe` are zero and `irq` is low; with pins held low, every address reads zero.
- R2: Writing word address 1 sets the drive-enable mask, one bit per pin, where 1 means output and 0 means input. `pin_oe` shows the written value after the write edge, and address 1 reads it back.
- R3: Writing word address 0 loads the drive latch for all pins in one write. `pin_out` shows the new value after the write edge, and address 2 reads it back unchanged.
- R4: Reading address 0 returns the pad inputs as sampled two rising edges earlier, regardless of drive direction, so a pin change is not visible there after only one edge.
- R5: Sense bits (address 6, address 5, address 4) are the per-pin bits C, B and A. When B=0 and A=0, the pin senses a falling edge and C is ignored. A rising input sets nothing in this mode.
- R6: When B=0, A=1 and C=0, the pin senses a rising edge only.
- R7: When B=0, A=1 and C=1, the pin senses both edges.
- R8: When B=1 and A=0, the pin senses a low level and C is ignored.
- R9: When B=1 and A=1, the pin senses a high level.
- R10: Writing address 7 clears each status bit written with 1 and leaves each bit written with 0 unchanged.
- R11: Status bits set even when the pin's enable (address 3) is 0. `irq` is the OR over pins of status AND enable, and a status bit changes to 0 only through a clearing write.
- R12: A level-mode status bit that is cleared while its level still holds reads 0 for one cycle and is set again on the next edge.
- R13: An edge event and a clearing write to the same bit on the same edge leave the bit set. Edge status is set on the third rising edge after the pin change.
- R14: Addresses 8 to 15 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pad input levels, asynchronous |
| pin_out | output | 32 | Pad output data, from the drive latch |
| pin_oe | output | 32 | Pad output enables, from the direction mask |
| irq | output | 1 | Combined interrupt request |

## Verification
Register writes show at the ports and in readback one rising edge after the write. A pin change reaches the level register after two edges, and it sets an event status bit, together with `irq` when the pin is enabled, on the third edge. The bench drives every input on a falling edge and samples one falling edge after the rising edge where each result is due. For the synchronized paths it also samples one edge early, to confirm that nothing shows up before its due cycle. For the same-edge case, the clearing write is timed to land on exactly the third edge after the pin change, and the level-reassert case samples in the single cycle in which the bit is clear.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;

   // Word offsets of the register file
   localparam int unsigned OFS_LEVEL  = 0;
   localparam int unsigned OFS_DIR    = 1;
   localparam int unsigned OFS_LATCH  = 2;
   localparam int unsigned OFS_IEN    = 3;
   localparam int unsigned OFS_SENSEA = 4;
   localparam int unsigned OFS_SENSEB = 5;
   localparam int unsigned OFS_SENSEC = 6;
   localparam int unsigned OFS_STAT   = 7;
   localparam int unsigned OFS_LAST   = OFS_STAT;

   typedef enum logic [2:0] {
      SENSE_FALL = 3'd0,
      SENSE_RISE = 3'd1,
      SENSE_BOTH = 3'd2,
      SENSE_LOW  = 3'd3,
      SENSE_HIGH = 3'd4
   } sense_e;

   // a: edge/level polarity, b: level select, c: second-edge select
   function automatic sense_e decode_sense(input logic a, input logic b, input logic c);
      if (b)
         return a ? SENSE_HIGH : SENSE_LOW;
      else if (!a)
         return SENSE_FALL;
      else
         return c ? SENSE_BOTH : SENSE_RISE;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] sync_o,
   output logic [WIDTH-1:0] prev_o
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];
   logic [WIDTH-1:0] prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   // One more register holds the previous synchronized value for edge compare
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= stage_q[LAST];
   end

   assign sync_o = stage_q[LAST];
   assign prev_o = prev_q;

endmodule

// File: rtl/gpio_event_detect.sv
`timescale 1ns/1ps
module gpio_event_detect
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] prev_i,
   input  logic [WIDTH-1:0] sense_a_i,
   input  logic [WIDTH-1:0] sense_b_i,
   input  logic [WIDTH-1:0] sense_c_i,
   output logic [WIDTH-1:0] edge_o,
   output logic [WIDTH-1:0] level_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic   rise, fall, e_bit, l_bit;
      sense_e mode;

      assign rise = cur_i[i] & ~prev_i[i];
      assign fall = ~cur_i[i] & prev_i[i];
      assign mode = decode_sense(sense_a_i[i], sense_b_i[i], sense_c_i[i]);

      always_comb begin
         e_bit = 1'b0;
         l_bit = 1'b0;
         case (mode)
            SENSE_FALL: e_bit = fall;
            SENSE_RISE: e_bit = rise;
            SENSE_BOTH: e_bit = rise | fall;
            SENSE_LOW:  l_bit = ~cur_i[i];
            SENSE_HIGH: l_bit = cur_i[i];
            default:    e_bit = 1'b0;
         endcase
      end

      assign edge_o[i]  = e_bit;
      assign level_o[i] = l_bit;
   end

endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] edge_i,
   input  logic [WIDTH-1:0] level_i,
   input  logic [WIDTH-1:0] clear_i,
   input  logic [WIDTH-1:0] enable_i,
   output logic [WIDTH-1:0] stat_o,
   output logic             irq_o
);

   logic [WIDTH-1:0] stat_q;
   logic [WIDTH-1:0] stat_d;

   // Edge events beat a same-edge clear; a level clear wins for one cycle
   always_comb begin
      stat_d = (stat_q & ~clear_i) | edge_i | (level_i & ~clear_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

   assign stat_o = stat_q;
   assign irq_o  = |(stat_q & enable_i);

endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS        = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   pin_in,
   output logic [PINS-1:0]   pin_out,
   output logic [PINS-1:0]   pin_oe,
   output logic              irq
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (PINS < 1 || PINS > DATA_W) begin : g_bad_pins
      $error("gpio_irq_bank: PINS must lie in 1..DATA_W");
   end
   if (ADDR_SPAN <= OFS_LAST) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W too narrow for the register file");
   end

   logic            wr_en;
   logic [PINS-1:0] wdata;
   logic [PINS-1:0] latch_q, dir_q, ien_q, sa_q, sb_q, sc_q;
   logic [PINS-1:0] sync_lv, prev_lv;
   logic [PINS-1:0] edge_evt, level_hit, clr_mask, stat_q;
   logic [PINS-1:0] rsel;

   assign wr_en = bus_sel & bus_wr;
   assign wdata = bus_wdata[PINS-1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   // Control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         ien_q   <= '0;
         sa_q    <= '0;
         sb_q    <= '0;
         sc_q    <= '0;
      end else if (wr_en) begin
         if (hit(bus_addr, OFS_LEVEL))  latch_q <= wdata;
         if (hit(bus_addr, OFS_DIR))    dir_q   <= wdata;
         if (hit(bus_addr, OFS_IEN))    ien_q   <= wdata;
         if (hit(bus_addr, OFS_SENSEA)) sa_q    <= wdata;
         if (hit(bus_addr, OFS_SENSEB)) sb_q    <= wdata;
         if (hit(bus_addr, OFS_SENSEC)) sc_q    <= wdata;
      end
   end

   assign clr_mask = (wr_en && hit(bus_addr, OFS_STAT)) ? wdata : '0;

   gpio_in_sync #(
      .WIDTH (PINS),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_in),
      .sync_o(sync_lv),
      .prev_o(prev_lv)
   );

   gpio_event_detect #(
      .WIDTH(PINS)
   ) u_detect (
      .cur_i    (sync_lv),
      .prev_i   (prev_lv),
      .sense_a_i(sa_q),
      .sense_b_i(sb_q),
      .sense_c_i(sc_q),
      .edge_o   (edge_evt),
      .level_o  (level_hit)
   );

   gpio_irq_status #(
      .WIDTH(PINS)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .edge_i  (edge_evt),
      .level_i (level_hit),
      .clear_i (clr_mask),
      .enable_i(ien_q),
      .stat_o  (stat_q),
      .irq_o   (irq)
   );

   // Read mux
   always_comb begin
      rsel = '0;
      if      (hit(bus_addr, OFS_LEVEL))  rsel = sync_lv;
      else if (hit(bus_addr, OFS_DIR))    rsel = dir_q;
      else if (hit(bus_addr, OFS_LATCH))  rsel = latch_q;
      else if (hit(bus_addr, OFS_IEN))    rsel = ien_q;
      else if (hit(bus_addr, OFS_SENSEA)) rsel = sa_q;
      else if (hit(bus_addr, OFS_SENSEB)) rsel = sb_q;
      else if (hit(bus_addr, OFS_SENSEC)) rsel = sc_q;
      else if (hit(bus_addr, OFS_STAT))   rsel = stat_q;
   end

   if (PINS == DATA_W) begin : g_full_word
      assign bus_rdata = rsel;
   end else begin : g_pad_word
      assign bus_rdata = {{(DATA_W-PINS){1'b0}}, rsel};
   end

   assign pin_out = latch_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_irq_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PINS   = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [PINS-1:0]   pin_in,
   input logic [PINS-1:0]   pin_out,
   input logic [PINS-1:0]   pin_oe,
   input logic              irq,
   input logic [PINS-1:0]   stat_q,
   input logic [PINS-1:0]   ien_q,
   input logic [PINS-1:0]   edge_evt
);

   logic       wr;
   logic [1:0] since_rst;

   assign wr = bus_sel && bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 3) since_rst <= since_rst + 2'd1;
   end

   // R2
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFS_DIR)) |=> pin_oe == $past(bus_wdata[PINS-1:0]));

   // R3
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFS_LEVEL)) |=> pin_out == $past(bus_wdata[PINS-1:0]));

   // R4
   level_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2 && bus_addr == ADDR_W'(OFS_LEVEL)) |->
         bus_rdata[PINS-1:0] == $past(pin_in, 2));

   // R10
   stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(OFS_STAT)) |=>
         (stat_q & $past(bus_wdata[PINS-1:0]) & ~$past(edge_evt)) == '0);

   // R11
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && bus_addr == ADDR_W'(OFS_STAT)) |=> ($past(stat_q) & ~stat_q) == '0);

   // R11
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |-> !irq);

   // R13
   edge_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_evt) |=> ($past(edge_evt) & ~stat_q) == '0);

   // R14
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > ADDR_W'(OFS_LAST)) |-> bus_rdata == '0);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
   .PINS  (PINS),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pin_in   (pin_in),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .irq      (irq),
   .stat_q   (stat_q),
   .ien_q    (ien_q),
   .edge_evt (edge_evt)
);

// File: tb/tb_gpio_irq_bank.sv
`timescale 1ns/1ps
module tb_gpio_irq_bank;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   gpio_irq_bank dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .irq      (irq)
   );

   localparam logic [3:0] A_LEVEL = 4'd0, A_DIR = 4'd1, A_LATCH = 4'd2, A_IEN = 4'd3,
                          A_SA = 4'd4, A_SB = 4'd5, A_SC = 4'd6, A_STAT = 4'd7;

   // {address, write data}: direction and latch writes, checked at ports and in readback
   localparam logic [35:0] VECS [6] = '{
      {4'd1, 32'hFFFF_0000},
      {4'd0, 32'hDEAD_BEEF},
      {4'd1, 32'h0000_0001},
      {4'd0, 32'h0000_0000},
      {4'd0, 32'h8000_0001},
      {4'd1, 32'h5A5A_A5A5}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   initial begin
      #(2_000_000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      tick(3);
      // R1 reset state
      chk("R1 pin_out", pin_out, 32'h0);
      chk("R1 pin_oe", pin_oe, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
      rst_n = 1'b1;
      tick(2);
      for (int a = 0; a < 8; a++) begin
         rd(4'(a), v);
         chk("R1 read", v, 32'h0);
      end

      // R2 / R3 vector walk
      for (int i = 0; i < 6; i++) begin
         wr(VECS[i][35:32], VECS[i][31:0]);
         if (VECS[i][35:32] == A_DIR) begin
            chk("R2 pin_oe", pin_oe, VECS[i][31:0]);
            rd(A_DIR, v);
            chk("R2 readback", v, VECS[i][31:0]);
         end else begin
            chk("R3 pin_out", pin_out, VECS[i][31:0]);
            rd(A_LATCH, v);
            chk("R3 readback", v, VECS[i][31:0]);
         end
      end

      // R4 synchronized level read, pins driven as outputs with a different latch
      wr(A_DIR, 32'hFFFF_FFFF);
      wr(A_LEVEL, 32'hA5A5_A5A5);
      pin_in = 32'h0F0F_3C3C;
      tick(1);
      rd(A_LEVEL, v);
      chk("R4 one edge", v, 32'h0);
      tick(1);
      rd(A_LEVEL, v);
      chk("R4 two edges", v, 32'h0F0F_3C3C);
      rd(A_LATCH, v);
      chk("R4 latch kept", v, 32'hA5A5_A5A5);
      pin_in = '0;
      tick(4);
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, v);
      chk("R10 clear all", v, 32'h0);

      // R5 falling (all sense bits 0); rise ignored
      pin_in[5] = 1'b1;
      tick(4);
      rd(A_STAT, v);
      chk("R5 rise ignored", v & 32'h20, 32'h0);
      pin_in[5] = 1'b0;
      tick(2);
      rd(A_STAT, v);
      chk("R5 not yet", v & 32'h20, 32'h0);
      tick(1);
      rd(A_STAT, v);
      chk("R5 fall set", v & 32'h20, 32'h20);

      // R6 rising only on pin 6, R7 both on pin 7
      wr(A_SA, 32'h0000_00C0);
      wr(A_SC, 32'h0000_0080);
      pin_in[6] = 1'b1; pin_in[7] = 1'b1;
      tick(2);
      rd(A_STAT, v);
      chk("R13 third edge", v & 32'hC0, 32'h0);
      tick(1);
      rd(A_STAT, v);
      chk("R6 R7 rise set", v & 32'hC0, 32'hC0);
      wr(A_STAT, 32'h0000_00C0);
      pin_in[6] = 1'b0; pin_in[7] = 1'b0;
      tick(3);
      rd(A_STAT, v);
      chk("R6 fall ignored", v & 32'h40, 32'h0);
      chk("R7 fall set", v & 32'h80, 32'h80);
      // R10 writing zeros leaves bits
      wr(A_STAT, 32'h0000_0000);
      rd(A_STAT, v);
      chk("R10 zero write", v & 32'hFF, 32'hA0);
      wr(A_STAT, 32'h0000_0080);
      rd(A_STAT, v);
      chk("R10 one clears", v & 32'hFF, 32'h20);

      // R8 low level on pin 8, R12 reassert
      wr(A_SB, 32'h0000_0100);
      tick(1);
      rd(A_STAT, v);
      chk("R8 low set", v & 32'h100, 32'h100);
      wr(A_STAT, 32'h0000_0100);
      rd(A_STAT, v);
      chk("R12 cleared cycle", v & 32'h100, 32'h0);
      tick(1);
      rd(A_STAT, v);
      chk("R12 reasserted", v & 32'h100, 32'h100);
      wr(A_SB, 32'h0000_0000);
      wr(A_STAT, 32'hFFFF_FFFF);

      // R9 high level on pin 10
      wr(A_SA, 32'h0000_0440);
      wr(A_SB, 32'h0000_0400);
      tick(2);
      rd(A_STAT, v);
      chk("R9 low ignored", v & 32'h400, 32'h0);
      pin_in[10] = 1'b1;
      tick(3);
      rd(A_STAT, v);
      chk("R9 high set", v & 32'h400, 32'h400);
      pin_in[10] = 1'b0;
      tick(3);
      wr(A_STAT, 32'h0000_0400);
      tick(1);
      rd(A_STAT, v);
      chk("R9 stays clear", v & 32'h400, 32'h0);

      // R13 rising event on pin 6 and its clear on the same edge
      wr(A_STAT, 32'hFFFF_FFFF);
      pin_in[6] = 1'b1;
      tick(1);
      @(posedge clk);
      @(negedge clk);
      wr(A_STAT, 32'h0000_0040);
      rd(A_STAT, v);
      chk("R13 event wins", v & 32'h40, 32'h40);

      // R11 status sets without enable; irq gating
      chk("R11 irq masked", {31'h0, irq}, 32'h0);
      wr(A_IEN, 32'h0000_0040);
      chk("R11 irq enabled", {31'h0, irq}, 32'h1);
      wr(A_IEN, 32'h0000_0020);
      chk("R11 other enable", {31'h0, irq}, 32'h0);
      wr(A_IEN, 32'h0000_0040);
      wr(A_STAT, 32'h0000_0040);
      chk("R11 cleared irq", {31'h0, irq}, 32'h0);

      // R14 unmapped addresses
      wr(A_DIR, 32'h1234_5678);
      wr(A_LEVEL, 32'h0BAD_F00D);
      wr(4'd12, 32'hFFFF_FFFF);
      wr(4'd15, 32'hFFFF_FFFF);
      chk("R14 pin_oe kept", pin_oe, 32'h1234_5678);
      chk("R14 pin_out kept", pin_out, 32'h0BAD_F00D);
      rd(4'd12, v);
      chk("R14 read zero", v, 32'h0);
      rd(A_IEN, v);
      chk("R14 enable kept", v, 32'h0000_0040);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule